// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block turns a software-selected power mode into registered enables for the CPU, the main clock, the sub-main (peripheral) clock, the auxiliary clock, the oscillator DC generator and the crystal oscillator. There are six modes: one run mode and five sleep levels of increasing depth. Each level switches off more of the clock tree. The enables are updated only on an edge of the always-on reference clock, so the downstream clock gates never see a glitch.

Any interrupt request wakes the block to run mode so that the handler can execute. The mode that was in force when the request arrived is saved. A return-from-interrupt strobe reinstates it. A mode write made while the handler runs changes the saved mode, so the handler decides the mode to return to. After reset, the first fetched reset vector is examined. If it reads all ones, meaning the memory is unprogrammed, the block drops straight into the deepest sleep level.

Top module: `lpm_clock_gate`

## Requirements
- R1: After reset, all six outputs (cpu_run, mclk_en, smclk_en, aclk_en, dcgen_en, xosc_en) are 1.
- R2: Mode code 0 (run) drives all six outputs to 1.
- R3: Mode code 1 (sleep level 0) drives cpu_run and mclk_en to 0 and keeps smclk_en, aclk_en, dcgen_en and xosc_en at 1.
- R4: Mode code 2 (sleep level 1) gives the same outputs as code 1, except that dcgen_en equals the dco_used input: the DC generator is off when the oscillator is not the run-mode clock source.
- R5: Mode code 3 (sleep level 2) drives cpu_run, mclk_en and smclk_en to 0 and keeps aclk_en, dcgen_en and xosc_en at 1.
- R6: Mode code 4 (sleep level 3) drives cpu_run, mclk_en, smclk_en and dcgen_en to 0 and keeps aclk_en and xosc_en at 1.
- R7: Mode code 5 (sleep level 4) drives all six outputs to 0.
- R8: The undefined codes 6 and 7 behave as code 5.
- R9: When irq_pend is high and no handler is active, the block enters run mode and becomes handler-active. The mode in force before that edge is saved.
- R10: When irq_ret is high while a handler is active, the saved mode is reinstated and the block leaves the handler-active state.
- R11: A mode write (mode_we) while the block sleeps is ignored. A write in run mode outside a handler takes effect as the current mode.
- R12: A mode write while a handler is active leaves run mode in force and replaces the saved mode that irq_ret will reinstate.
- R13: On the first vec_vld after reset, a vec_val of all ones (0xFFFF) forces code 5. Any other value leaves the mode unchanged. Every later vec_vld is ignored.
- R14: The priority among events in one cycle is: vector force, then return, then interrupt entry, then mode write. irq_pend during a handler and irq_ret outside a handler are ignored. All outputs change on the edge that samples the causing input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode write strobe from software |
| mode_code | input | MODE_W | Requested mode code (0 run, 1..5 sleep levels 0..4) |
| dco_used | input | 1 | High when the controlled oscillator sources a clock in run mode |
| irq_pend | input | 1 | Interrupt request pending |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| vec_vld | input | 1 | Reset vector fetch valid |
| vec_val | input | VEC_W | Fetched reset vector value |
| cpu_run | output | 1 | CPU allowed to execute |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Sub-main clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| dcgen_en | output | 1 | Oscillator DC generator enable |
| xosc_en | output | 1 | Crystal oscillator enable |

## Verification
Every result of this block is due on the first clock edge that samples the causing input. This covers mode writes, wakes, returns, the vector force, and dco_used changes seen in sleep level 1. The bench drives all inputs just after a falling edge. It drops each strobe after a single rising edge and compares the six outputs with its reference model at the following falling edge, halfway through the cycle. The reference model is advanced exactly once per driven cycle, so every expected value lines up with the edge that produced it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [2:0] {
      PM_RUN = 3'd0,
      PM_L0  = 3'd1,
      PM_L1  = 3'd2,
      PM_L2  = 3'd3,
      PM_L3  = 3'd4,
      PM_L4  = 3'd5
   } pm_mode_e;

   typedef struct packed {
      logic cpu;
      logic mclk;
      logic smclk;
      logic aclk;
      logic dcgen;
      logic xosc;
   } pm_en_t;

   localparam int EN_W = $bits(pm_en_t);

endpackage

// File: rtl/pmc_mode_seq.sv
module pmc_mode_seq
   import pmc_pkg::*;
#(
   parameter int MODE_W = 3,
   parameter int VEC_W  = 16,
   parameter logic [VEC_W-1:0] UNPROG_VEC = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_code,
   input  logic              irq_pend,
   input  logic              irq_ret,
   input  logic              vec_vld,
   input  logic [VEC_W-1:0]  vec_val,
   output pm_mode_e          mode_d,
   output pm_mode_e          mode_q
);

   localparam int MAX_CODE = 5;

   pm_mode_e saved_q, saved_d;
   logic     isr_q, isr_d;
   logic     seen_q;
   logic     force_deep;
   pm_mode_e req_mode;

   always_comb begin
      if (mode_code > MODE_W'(MAX_CODE)) req_mode = PM_L4;
      else                               req_mode = pm_mode_e'(mode_code[2:0]);
   end

   assign force_deep = vec_vld && !seen_q && (vec_val == UNPROG_VEC);

   always_comb begin
      mode_d  = mode_q;
      saved_d = saved_q;
      isr_d   = isr_q;
      if (force_deep) begin
         mode_d = PM_L4;
         isr_d  = 1'b0;
      end else if (irq_ret && isr_q) begin
         mode_d = saved_q;
         isr_d  = 1'b0;
      end else if (irq_pend && !isr_q) begin
         saved_d = mode_q;
         mode_d  = PM_RUN;
         isr_d   = 1'b1;
      end else if (mode_we && mode_q == PM_RUN) begin
         if (isr_q) saved_d = req_mode;
         else       mode_d  = req_mode;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= PM_RUN;
         saved_q <= PM_RUN;
         isr_q   <= 1'b0;
         seen_q  <= 1'b0;
      end else begin
         mode_q  <= mode_d;
         saved_q <= saved_d;
         isr_q   <= isr_d;
         if (vec_vld) seen_q <= 1'b1;
      end
   end

   // R9: a request outside a handler brings run mode on the next edge
   p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && !isr_q && !force_deep) |=> (mode_q == PM_RUN && isr_q));

   // R10: the return strobe reinstates the saved mode
   p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && isr_q && !force_deep) |=> (mode_q == $past(saved_q) && !isr_q));

   // R11: writes while asleep leave the mode untouched
   p_sleep_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != PM_RUN && mode_we && !irq_pend && !force_deep) |=> $stable(mode_q));

   // R13: unprogrammed vector on the first fetch forces the deepest level
   p_force_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_vld && !seen_q && vec_val == UNPROG_VEC) |=> (mode_q == PM_L4));

   // R12: a handler always runs in run mode
   p_isr_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
      isr_q |-> (mode_q == PM_RUN));

endmodule

// File: rtl/pmc_en_decode.sv
module pmc_en_decode
   import pmc_pkg::*;
(
   input  pm_mode_e mode,
   input  logic     dco_used,
   output pm_en_t   en
);

   always_comb begin
      en = '1;
      unique case (mode)
         PM_RUN: en = '1;
         PM_L0: begin
            en.cpu  = 1'b0;
            en.mclk = 1'b0;
         end
         PM_L1: begin
            en.cpu   = 1'b0;
            en.mclk  = 1'b0;
            en.dcgen = dco_used;
         end
         PM_L2: begin
            en.cpu   = 1'b0;
            en.mclk  = 1'b0;
            en.smclk = 1'b0;
         end
         PM_L3: begin
            en.cpu   = 1'b0;
            en.mclk  = 1'b0;
            en.smclk = 1'b0;
            en.dcgen = 1'b0;
         end
         default: en = '0;
      endcase
   end

endmodule

// File: rtl/pmc_en_reg.sv
module pmc_en_reg #(
   parameter int             W       = 6,
   parameter logic [W-1:0]   RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= RST_VAL[i];
         else        q[i] <= d[i];
      end
   end

endmodule

// File: rtl/lpm_clock_gate.sv
module lpm_clock_gate
   import pmc_pkg::*;
#(
   parameter int MODE_W = 3,
   parameter int VEC_W  = 16,
   parameter logic [VEC_W-1:0] UNPROG_VEC = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_code,
   input  logic              dco_used,
   input  logic              irq_pend,
   input  logic              irq_ret,
   input  logic              vec_vld,
   input  logic [VEC_W-1:0]  vec_val,
   output logic              cpu_run,
   output logic              mclk_en,
   output logic              smclk_en,
   output logic              aclk_en,
   output logic              dcgen_en,
   output logic              xosc_en
);

   if (MODE_W < 3) begin : g_bad_mode_w
      $error("MODE_W must hold codes 0 to 5");
   end
   if (VEC_W < 1) begin : g_bad_vec_w
      $error("VEC_W must be positive");
   end

   pm_mode_e mode_d, mode_q;
   pm_en_t   en_d, en_q;

   pmc_mode_seq #(
      .MODE_W(MODE_W), .VEC_W(VEC_W), .UNPROG_VEC(UNPROG_VEC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .mode_we(mode_we), .mode_code(mode_code),
      .irq_pend(irq_pend), .irq_ret(irq_ret),
      .vec_vld(vec_vld), .vec_val(vec_val),
      .mode_d(mode_d), .mode_q(mode_q)
   );

   pmc_en_decode u_dec (
      .mode(mode_d), .dco_used(dco_used), .en(en_d)
   );

   pmc_en_reg #(.W(EN_W), .RST_VAL({EN_W{1'b1}})) u_reg (
      .clk(clk), .rst_n(rst_n), .d(en_d), .q(en_q)
   );

   assign cpu_run  = en_q.cpu;
   assign mclk_en  = en_q.mclk;
   assign smclk_en = en_q.smclk;
   assign aclk_en  = en_q.aclk;
   assign dcgen_en = en_q.dcgen;
   assign xosc_en  = en_q.xosc;

   // R3: the main clock never runs while the CPU is stopped
   p_cpu_mclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_run |-> !mclk_en);

   // R5: with the sub-main clock gated the CPU is stopped as well
   p_smclk_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !smclk_en |-> (!mclk_en && !cpu_run));

   // R7: the auxiliary clock only stops in the deepest level, where all is off
   p_deep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !aclk_en |-> !(smclk_en || dcgen_en || xosc_en || cpu_run));

   // R2: the stored mode and the registered enables agree on run mode
   p_run_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_RUN) |-> (cpu_run && smclk_en && aclk_en && xosc_en && dcgen_en));

endmodule

// File: tb/lpm_clock_gate_test.sv
`timescale 1ns/1ps
module lpm_clock_gate_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_we = 1'b0;
   logic [2:0]  mode_code = 3'd0;
   logic        dco_used = 1'b1;
   logic        irq_pend = 1'b0;
   logic        irq_ret = 1'b0;
   logic        vec_vld = 1'b0;
   logic [15:0] vec_val = 16'h0;
   logic        cpu_run, mclk_en, smclk_en, aclk_en, dcgen_en, xosc_en;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   int m_mode, m_saved;
   bit m_isr, m_seen;

   always #2 clk = ~clk;

   lpm_clock_gate uut (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_code(mode_code),
      .dco_used(dco_used), .irq_pend(irq_pend), .irq_ret(irq_ret),
      .vec_vld(vec_vld), .vec_val(vec_val),
      .cpu_run(cpu_run), .mclk_en(mclk_en), .smclk_en(smclk_en),
      .aclk_en(aclk_en), .dcgen_en(dcgen_en), .xosc_en(xosc_en)
   );

   function automatic int norm(input logic [2:0] c);
      return (c > 3'd5) ? 5 : int'(c);
   endfunction

   // bit order {cpu, mclk, smclk, aclk, dcgen, xosc}
   function automatic logic [5:0] exp_en(input int mode, input logic dco);
      case (mode)
         0: return 6'b111111;
         1: return 6'b001111;
         2: return {4'b0011, dco, 1'b1};
         3: return 6'b000111;
         4: return 6'b000101;
         default: return 6'b000000;
      endcase
   endfunction

   function automatic string tag_of(input int mode);
      case (mode)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string req);
      logic [5:0] act, exp;
      act = {cpu_run, mclk_en, smclk_en, aclk_en, dcgen_en, xosc_en};
      exp = exp_en(m_mode, dco_used);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: outputs actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic model_step(input bit we, input logic [2:0] code, input bit irq,
                             input bit ret, input bit vv, input logic [15:0] vec);
      bit frc;
      frc = vv && !m_seen && (vec == 16'hFFFF);
      if (vv) m_seen = 1'b1;
      if (frc) begin
         m_mode = 5; m_isr = 1'b0;
      end else if (ret && m_isr) begin
         m_mode = m_saved; m_isr = 1'b0;
      end else if (irq && !m_isr) begin
         m_saved = m_mode; m_mode = 0; m_isr = 1'b1;
      end else if (we && m_mode == 0) begin
         if (m_isr) m_saved = norm(code);
         else       m_mode  = norm(code);
      end
   endtask

   // drive at a falling edge, pass one rising edge, check at the next falling edge
   task automatic drive(input bit we, input logic [2:0] code, input bit irq,
                        input bit ret, input bit vv, input logic [15:0] vec,
                        input string req);
      mode_we = we; mode_code = code; irq_pend = irq; irq_ret = ret;
      vec_vld = vv; vec_val = vec;
      model_step(we, code, irq, ret, vv, vec);
      @(posedge clk);
      @(negedge clk);
      mode_we = 1'b0; irq_pend = 1'b0; irq_ret = 1'b0; vec_vld = 1'b0;
      if (req.len() > 0) check(req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      mode_we = 1'b0; irq_pend = 1'b0; irq_ret = 1'b0; vec_vld = 1'b0;
      m_mode = 0; m_saved = 0; m_isr = 1'b0; m_seen = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic back_to_run();
      drive(1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0, "R9");
      drive(1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0, "R12");
      drive(1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0, "R10");
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1CE5));
      do_reset();
      check("R1");

      // programmed vector keeps run mode, later unprogrammed vector ignored
      drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h4400, "R13");
      drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 16'hFFFF, "R13");

      // each mode code in turn, leaving through a handler that rewrites the saved mode
      for (int k = 1; k <= 5; k++) begin
         drive(1'b1, 3'(k), 1'b0, 1'b0, 1'b0, 16'h0, tag_of(k));
         back_to_run();
         check("R12");
      end

      // sleep level 1 with the oscillator unused in run mode
      dco_used = 1'b0;
      drive(1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 16'h0, "R4");
      dco_used = 1'b1;
      @(negedge clk);
      check("R4");
      back_to_run();

      // undefined codes
      drive(1'b1, 3'd6, 1'b0, 1'b0, 1'b0, 16'h0, "R8");
      back_to_run();
      drive(1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 16'h0, "R8");
      back_to_run();

      // write while asleep is ignored
      drive(1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 16'h0, "R5");
      drive(1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0, "R11");
      drive(1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0, "R11");

      // wake from level 3 and restore it
      back_to_run();
      drive(1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 16'h0, "R6");
      drive(1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0, "R9");
      drive(1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0, "R14");
      drive(1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0, "R10");
      back_to_run();

      // return outside a handler is ignored; interrupt beats a same-cycle write
      drive(1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0, "R14");
      drive(1'b1, 3'd3, 1'b1, 1'b0, 1'b0, 16'h0, "R14");
      drive(1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0, "R14");
      drive(1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 16'h0, "R11");
      // return and interrupt together inside a handler: return wins
      drive(1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0, "R9");
      drive(1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 16'h0, "R14");

      // unprogrammed vector after reset forces the deepest level
      do_reset();
      check("R1");
      drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 16'hFFFF, "R13");
      drive(1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0, "R9");
      drive(1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0, "R10");

      // constrained random traffic
      do_reset();
      for (int n = 0; n < 3000; n++) begin
         bit we, irq, ret, vv;
         logic [2:0] code;
         logic [15:0] vec;
         we   = ($urandom_range(99) < 35);
         irq  = ($urandom_range(99) < 12);
         ret  = ($urandom_range(99) < 15);
         vv   = ($urandom_range(99) < 2);
         code = 3'($urandom_range(7));
         vec  = ($urandom_range(1) == 1) ? 16'hFFFF : 16'($urandom);
         if ($urandom_range(99) < 10) dco_used = ~dco_used;
         drive(we, code, irq, ret, vv, vec, "");
         check(tag_of(m_mode));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule